// File: doc/BRIEF.md
# Three-Channel Edge Event Monitor

The block watches three external event pins and turns a chosen edge on each into a sticky event flag. A flagged event can raise an interrupt request and a wake-up request. It can also emit a one-cycle strobe that wipes a neighbouring bank of general-purpose retention registers. Each pin first passes through a two-stage synchronizer. The synchronized value is then gated by the channel's input enable; a disabled input reads internally as logic high. Edge detection compares this gated value with its value one cycle earlier.

Software reaches the block through a small synchronous register port. Address 0 holds the control word. Each channel owns a 10-bit slice of it starting at bit 10*n, and only the low four bits of each slice are implemented. Address 1 shows the event flags, and writing ones there clears them. Read data is combinational on the address.

Top module: `evt_edge_monitor`

## Requirements
- R1: The control word at address 0 holds channel n's settings at bit 10*n + k, with k = 0 interrupt/wake enable, k = 1 general-purpose-clear enable, k = 2 polarity, k = 3 input enable. A write with reg_wr high and reg_addr = 0 replaces these bits at the clock edge; otherwise they hold.
- R2: After reset, every control bit, every flag, irq, wake and gp_clear are 0.
- R3: With the input enabled, polarity 1 treats a rising pin edge as an event and polarity 0 treats a falling edge as one. The opposite edge is ignored. The flag rises on the third rising clock edge after the pin changes.
- R4: While a channel's input enable is 0, its internal input is forced high, so pin activity produces no event.
- R5: Setting the input enable while the pin is low produces a falling internal edge. With polarity 0 this is an event, flagged one clock edge after the control write.
- R6: A flag stays set until software writes 1 to bit n at address 1. Writing 0 there leaves it alone. An event in the same cycle as the clear keeps the flag set.
- R7: irq and wake are both high exactly when some channel has its flag set and its interrupt/wake enable at 1.
- R8: gp_clear is a one-cycle pulse in the cycle the flag rises. It appears only for a channel whose general-purpose-clear enable is 1.
- R9: At address 0, bits 4 to 9 of each slice and bits 30 and 31 read as 0 and ignore writes. At address 1, bits above the three flags read 0.
- R10: reg_rdata shows the word chosen by reg_addr in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_pin | input | 3 | Asynchronous event pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = flags (write 1 to clear) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_flag | output | 3 | Sticky event flags |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |
| gp_clear | output | 1 | One-cycle wipe strobe for the retention registers |

## Verification
A wrong synchronizer depth or edge-history value shows up as a flag that rises one cycle early or late. It can also show up as a flag raised on the wrong edge. Either way it is visible three edges after a pin change. A corrupted control bit reads back wrongly at address 0 in the same cycle. It also changes which pins set flags and whether irq or gp_clear follow them. A flag register that loses or keeps state wrongly is exposed on ev_flag and irq one cycle after the event or the clear. This includes the case where a clear and an event collide.

// File: rtl/evm_pkg.sv
package evm_pkg;
  // width of each channel's slice in the control word
  localparam int SLICE_W = 10;
  // field positions inside a slice
  localparam int F_IRQ  = 0;
  localparam int F_GPC  = 1;
  localparam int F_POL  = 2;
  localparam int F_INEN = 3;
  localparam int F_NUM  = 4;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // packed so that bit k of the struct equals field k of the slice
  typedef struct packed {
    logic in_en;
    logic pol;
    logic gpc_en;
    logic irq_en;
  } ch_cfg_t;
endpackage

// File: rtl/evm_rst_sync.sv
module evm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/evm_sync.sv
module evm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RESET_VAL}};
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evm_channel.sv
module evm_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic in_en_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic ev_o,
  output logic flag_o
);
  logic gated;
  logic prev_q;
  logic flag_q;
  logic flag_d;

  // disabled input reads as high
  always_comb begin
    gated = in_en_i ? pin_s_i : 1'b1;
    ev_o  = pol_i ? (~prev_q & gated) : (prev_q & ~gated);
    // a new event beats a simultaneous clear
    flag_d = ev_o | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= gated;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  p_event_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o |=> flag_o);

  p_clear_drops_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ev_o) |=> !flag_o);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_en_i && $past(!in_en_i)) |-> !ev_o);
endmodule

// File: rtl/evm_regs.sv
module evm_regs
  import evm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_i,
  input  logic                        addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_CH-1:0]           flags_i,
  output ch_cfg_t [NUM_CH-1:0]        cfg_o,
  output logic [NUM_CH-1:0]           w1c_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int CFG_W = $bits(ch_cfg_t);

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) m[i*SLICE_W +: CFG_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

  ch_cfg_t [NUM_CH-1:0] cfg_q;
  ch_cfg_t [NUM_CH-1:0] cfg_d;
  logic                 ctrl_we;
  logic                 stat_we;
  logic [DATA_W-1:0]    ctrl_view;
  logic [DATA_W-1:0]    stat_view;
  logic                 unused_wdata;

  assign ctrl_we      = wr_i && (addr_i == ADDR_CTRL);
  assign stat_we      = wr_i && (addr_i == ADDR_STAT);
  assign unused_wdata = ^wdata_i;

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 0; i < NUM_CH; i++) cfg_d[i] = wdata_i[i*SLICE_W +: CFG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (ctrl_we) cfg_q <= cfg_d;
  end

  always_comb begin
    ctrl_view = '0;
    for (int i = 0; i < NUM_CH; i++) ctrl_view[i*SLICE_W +: CFG_W] = cfg_q[i];
    stat_view = '0;
    stat_view[NUM_CH-1:0] = flags_i;
    rdata_o = (addr_i == ADDR_CTRL) ? ctrl_view : stat_view;
    w1c_o   = stat_we ? wdata_i[NUM_CH-1:0] : '0;
  end

  assign cfg_o = cfg_q;

  p_ctrl_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(cfg_q));

  p_rsvd_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_CTRL) |-> ((rdata_o & ~CTRL_MASK) == '0));

  p_no_clear_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |-> (w1c_o == '0));
endmodule

// File: rtl/evt_edge_monitor.sv
module evt_edge_monitor
  import evm_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_pin,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] ev_flag,
  output logic              irq,
  output logic              wake,
  output logic              gp_clear
);
  logic                 rst_n_s;
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]    w1c;
  logic [NUM_CH-1:0]    pin_s;
  logic [NUM_CH-1:0]    ev;
  logic [NUM_CH-1:0]    flag;
  logic [NUM_CH-1:0]    irq_en_v;
  logic [NUM_CH-1:0]    gpc_en_v;
  logic                 gpc_q;
  logic                 gpc_d;

  evm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  evm_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .flags_i (flag),
    .cfg_o   (cfg),
    .w1c_o   (w1c),
    .rdata_o (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n_s),
      .d_i   (ev_pin[g]),
      .q_o   (pin_s[g])
    );

    evm_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .pin_s_i (pin_s[g]),
      .in_en_i (cfg[g].in_en),
      .pol_i   (cfg[g].pol),
      .clr_i   (w1c[g]),
      .ev_o    (ev[g]),
      .flag_o  (flag[g])
    );

    assign irq_en_v[g] = cfg[g].irq_en;
    assign gpc_en_v[g] = cfg[g].gpc_en;
  end

  always_comb begin
    gpc_d = |(ev & gpc_en_v);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) gpc_q <= 1'b0;
    else          gpc_q <= gpc_d;
  end

  assign ev_flag  = flag;
  assign irq      = |(flag & irq_en_v);
  assign wake     = irq;
  assign gp_clear = gpc_q;

  p_irq_has_flag_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (ev_flag != '0));

  p_gpclr_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    gp_clear |-> $past(|gpc_en_v));

  p_gpclr_with_flag_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    gp_clear |-> (ev_flag != '0));
endmodule

// File: tb/evt_edge_monitor_bench.sv
module evt_edge_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 8;

  logic        clk;
  logic        rst_n;
  logic [2:0]  ev_pin;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  ev_flag;
  logic        irq, wake, gp_clear;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // {ch[1:0], slice{in_en,pol,gpc,irq}[3:0], start, end, exp_flag, exp_gpc, exp_irq}
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 4'b1101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd0, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'b1011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd1, 4'b1011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'b1110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd2, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  evt_edge_monitor u_evt_edge_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_pin    (ev_pin),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_flag   (ev_flag),
    .irq       (irq),
    .wake      (wake),
    .gp_clear  (gp_clear)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_pin = 3'b000; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    reg_addr = 1'b0; #1;
    check("R2 ctrl after reset", reg_rdata, 32'h0);
    reg_addr = 1'b1; #1;
    check("R2 flags read after reset", reg_rdata, 32'h0);
    check("R2 outputs after reset", {ev_flag, irq, wake, gp_clear}, 32'h0);

    // R9 / R1: reserved bits read zero, defined bits land in place
    wr(1'b0, 32'hFFFF_FFFF);
    reg_addr = 1'b0; #1;
    check("R9 R1 ctrl readback all ones", reg_rdata, 32'h00F0_3C0F);
    wr(1'b0, 32'h0000_2004); // ch0 polarity bit 2, ch1 input enable bit 13
    reg_addr = 1'b0; #1;
    check("R1 ctrl field positions", reg_rdata, 32'h0000_2004);

    // R3 R4 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] ch;
      logic [3:0] sl;
      ch = VEC[v][10:9];
      sl = VEC[v][8:5];
      ev_pin = {3{VEC[v][4]}};
      wr(1'b0, 32'(sl) << (10 * ch));
      repeat (5) @(negedge clk);
      wr(1'b1, 32'h7);
      check($sformatf("R6 vec%0d flags clear before edge", v), 32'(ev_flag), 32'h0);
      ev_pin[ch] = VEC[v][3];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R3 R4 vec%0d flag", v), 32'(ev_flag), 32'(VEC[v][2]) << ch);
      check($sformatf("R8 vec%0d gp_clear", v), 32'(gp_clear), 32'(VEC[v][1]));
      check($sformatf("R7 vec%0d irq", v), 32'(irq), 32'(VEC[v][0]));
      check($sformatf("R7 vec%0d wake", v), 32'(wake), 32'(VEC[v][0]));
      @(negedge clk);
      check($sformatf("R8 vec%0d gp_clear one cycle", v), 32'(gp_clear), 32'h0);
    end

    // R5: enabling input with pin low, polarity 0
    wr(1'b0, 32'h0);
    ev_pin = 3'b000;
    repeat (5) @(negedge clk);
    wr(1'b1, 32'h7);
    wr(1'b0, 32'h0000_0009); // ch0: input enable + irq enable, polarity 0
    check("R5 no flag in write cycle", 32'(ev_flag), 32'h0);
    @(negedge clk);
    check("R5 enable on low pin flags event", 32'(ev_flag), 32'h1);
    check("R5 R7 irq after enable event", 32'(irq), 32'h1);

    // R6 / R10: readback, write 0 keeps, write 1 clears
    reg_addr = 1'b1; #1;
    check("R10 flags readback", reg_rdata, 32'h1);
    wr(1'b1, 32'h0);
    check("R6 write zero keeps flag", 32'(ev_flag), 32'h1);
    wr(1'b1, 32'hFFFF_FFFE);
    check("R6 R9 other bits leave ch0 flag", 32'(ev_flag), 32'h1);
    wr(1'b1, 32'h1);
    check("R6 write one clears flag", 32'(ev_flag), 32'h0);
    check("R7 irq drops after clear", 32'(irq), 32'h0);

    // R6: event colliding with clear keeps flag
    wr(1'b0, 32'h0000_000C); // ch0 enabled, polarity 1
    repeat (4) @(negedge clk);
    wr(1'b1, 32'h7);
    ev_pin[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(1'b1, 32'h1);
    check("R6 event beats clear", 32'(ev_flag), 32'h1);
    check("R7 irq off when irq enable 0", 32'(irq), 32'h0);

    // R4: disable then toggle pin
    wr(1'b0, 32'h0);
    repeat (4) @(negedge clk);
    wr(1'b1, 32'h7);
    ev_pin = 3'b000;
    repeat (4) @(negedge clk);
    ev_pin = 3'b111;
    repeat (4) @(negedge clk);
    check("R4 disabled pins raise nothing", {29'd0, ev_flag}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule